// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

This block watches the command bus of a single-data-rate SDRAM and checks every clock that the controller keeps to the device's spacing rules. It decodes the chip-select, row-strobe, column-strobe and write-enable pins into commands. It tracks whether each bank is open or closed, and it counts cycles since the last activate, precharge and write of each bank. Two bus-wide counters measure the time since the last activate to any bank and the time since the last mode-register load.

When a rule is broken, the monitor pulses a flag one clock after the offending command. The first violation is latched into a sticky error flag, together with a 4-bit code for the rule and the number of the bank. The monitor never drives the bus. All limits are parameters given in clock cycles. The defaults match a device clocked at 133 MHz, with a maximum row-open time of 100 µs expressed as 13334 cycles.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Reset clears the pulse, the sticky flag, the code and the bank, and leaves every bank closed. Commands are decoded only while cmd_cs_n is low, from {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode load. Every other pattern, and any cycle with cmd_cs_n high, is a no-op that triggers no check.
- R2: A read or write to an open bank fewer than TRCD_CYC cycles after that bank's activate reports code 1.
- R3: An activate fewer than TRP_CYC cycles after a precharge of that bank reports code 2. A precharge-all counts as a precharge of every bank.
- R4: A precharge of an open bank fewer than TRAS_CYC cycles after its activate reports code 3.
- R5: A bank that stays open for more than TRAS_MAX_CYC cycles reports code 4. It is reported exactly once, in the cycle its open time reaches TRAS_MAX_CYC+1. A later precharge of that bank adds no further report.
- R6: Two activates to the same bank fewer than TRC_CYC cycles apart report code 5.
- R7: An activate to a bank other than the one last activated, fewer than TRRD_CYC cycles after that activate, reports code 6 against the new bank.
- R8: A precharge of an open bank fewer than TWR_CYC cycles after a write to it reports code 7.
- R9: Any decoded command fewer than TMRD_CYC cycles after a mode load reports code 8 against the command's bank field.
- R10: A read or write to a closed bank reports code 9. An activate to a bank that is already open reports code 10.
- R11: Reads and writes to an open bank may follow one another on every cycle with no report.
- R12: viol_pulse is high for one cycle, one clock after each violating command. The first violation sets err_flag and loads err_code/err_bank, which then hold until err_clear is high at a clock edge. A violation in that same cycle is loaded fresh. When several rules break at once, the lowest code wins, and then the lowest bank.
- R13: A precharge with cmd_a10 high closes all banks and checks the tRAS minimum and write recovery of each bank that was open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_cs_n | input | 1 | Chip select, active low |
| cmd_ras_n | input | 1 | Row strobe, active low |
| cmd_cas_n | input | 1 | Column strobe, active low |
| cmd_we_n | input | 1 | Write enable, active low |
| cmd_ba | input | 2 | Bank address |
| cmd_a10 | input | 1 | Address bit 10 (all-banks qualifier for precharge) |
| err_clear | input | 1 | Clears the latched error |
| viol_pulse | output | 1 | One-cycle report of any violation |
| err_flag | output | 1 | Sticky error flag |
| err_code | output | 4 | Code of the first latched rule |
| err_bank | output | 2 | Bank of the first latched rule |

## Verification
The bench keeps the short default cycle limits: two cycles for activate-to-column, precharge, activate-to-activate across banks, write recovery and mode load; six for the minimum row-open time; eight for same-bank activate spacing. With these limits, every short-gap rule can be broken and also met within a few commands. It overrides the maximum row-open time to 40 cycles, so the once-only overrun report and its exact cycle come within a short run. Multi-bank cases, such as all-bank precharge with two banks too young, exercise the code-then-bank priority.

// File: rtl/sdr_mon_pkg.sv
package sdr_mon_pkg;

  typedef enum logic [2:0] {
    OP_NOP, OP_ACT, OP_RD, OP_WR, OP_PRE, OP_REF, OP_MRS
  } sdr_op_e;

  localparam int CODE_W = 4;
  localparam int RULE_N = 1 << CODE_W;
  typedef logic [RULE_N-1:0] rule_vec_t;

  // rule codes; lower value has higher report priority
  localparam logic [CODE_W-1:0] RULE_TRCD     = 4'd1;
  localparam logic [CODE_W-1:0] RULE_TRP      = 4'd2;
  localparam logic [CODE_W-1:0] RULE_TRAS_MIN = 4'd3;
  localparam logic [CODE_W-1:0] RULE_TRAS_MAX = 4'd4;
  localparam logic [CODE_W-1:0] RULE_TRC      = 4'd5;
  localparam logic [CODE_W-1:0] RULE_TRRD     = 4'd6;
  localparam logic [CODE_W-1:0] RULE_TWR      = 4'd7;
  localparam logic [CODE_W-1:0] RULE_TMRD     = 4'd8;
  localparam logic [CODE_W-1:0] RULE_CLOSED   = 4'd9;
  localparam logic [CODE_W-1:0] RULE_REOPEN   = 4'd10;

  function automatic sdr_op_e decode_op(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
    sdr_op_e r;
    r = OP_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  r = OP_ACT;
        3'b101:  r = OP_RD;
        3'b100:  r = OP_WR;
        3'b010:  r = OP_PRE;
        3'b001:  r = OP_REF;
        3'b000:  r = OP_MRS;
        default: r = OP_NOP;
      endcase
    end
    return r;
  endfunction

  // gap is the distance in cycles from the earlier event
  function automatic logic too_soon(input int unsigned gap, input int unsigned floor_cyc);
    return gap < floor_cyc;
  endfunction

  function automatic int unsigned sat_step(input int unsigned v, input int unsigned top);
    return (v >= top) ? top : v + 1;
  endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  output sdr_op_e              op,
  output logic [NUM_BANKS-1:0] bank_sel,
  output logic                 pre_all
);

  assign op      = decode_op(cs_n, ras_n, cas_n, we_n);
  assign pre_all = (op == OP_PRE) && a10;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
    assign bank_sel[g] = (ba == BA_W'(g));
  end

endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
  import sdr_mon_pkg::*;
#(
  parameter int TRCD_CYC     = 2,
  parameter int TRP_CYC      = 2,
  parameter int TRAS_CYC     = 6,
  parameter int TRAS_MAX_CYC = 13334,
  parameter int TRC_CYC      = 8,
  parameter int TWR_CYC      = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  sdr_op_e   op,
  input  logic      sel,
  input  logic      pre_all,
  output rule_vec_t rules
);

  localparam int ACT_TOP = (TRAS_MAX_CYC + 2 > TRC_CYC) ? TRAS_MAX_CYC + 2 : TRC_CYC;
  localparam int PRE_TOP = TRP_CYC;
  localparam int WR_TOP  = TWR_CYC;
  localparam int TOP_MAX = (ACT_TOP > PRE_TOP) ? ((ACT_TOP > WR_TOP) ? ACT_TOP : WR_TOP)
                                               : ((PRE_TOP > WR_TOP) ? PRE_TOP : WR_TOP);
  localparam int CW      = $clog2(TOP_MAX + 1);

  logic          open_q;
  logic [CW-1:0] act_cnt, pre_cnt, wr_cnt;

  // named events for this bank
  logic do_act, do_col, do_wr, do_pre, overrun;
  assign do_act  = sel && (op == OP_ACT);
  assign do_col  = sel && ((op == OP_RD) || (op == OP_WR));
  assign do_wr   = sel && (op == OP_WR) && open_q;
  assign do_pre  = (op == OP_PRE) && (sel || pre_all);
  assign overrun = open_q && (act_cnt == CW'(TRAS_MAX_CYC + 1));

  always_comb begin
    rules                = '0;
    rules[RULE_TRCD]     = do_col && open_q && too_soon(32'(act_cnt), TRCD_CYC);
    rules[RULE_CLOSED]   = do_col && !open_q;
    rules[RULE_TRP]      = do_act && too_soon(32'(pre_cnt), TRP_CYC);
    rules[RULE_TRC]      = do_act && too_soon(32'(act_cnt), TRC_CYC);
    rules[RULE_REOPEN]   = do_act && open_q;
    rules[RULE_TRAS_MIN] = do_pre && open_q && too_soon(32'(act_cnt), TRAS_CYC);
    rules[RULE_TWR]      = do_pre && open_q && too_soon(32'(wr_cnt), TWR_CYC);
    rules[RULE_TRAS_MAX] = overrun;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      act_cnt <= CW'(ACT_TOP);
      pre_cnt <= CW'(PRE_TOP);
      wr_cnt  <= CW'(WR_TOP);
    end else begin
      act_cnt <= do_act ? CW'(1) : CW'(sat_step(32'(act_cnt), ACT_TOP));
      pre_cnt <= do_pre ? CW'(1) : CW'(sat_step(32'(pre_cnt), PRE_TOP));
      wr_cnt  <= do_wr  ? CW'(1) : CW'(sat_step(32'(wr_cnt), WR_TOP));
      if (do_act)      open_q <= 1'b1;
      else if (do_pre) open_q <= 1'b0;
    end
  end

  p_act_opens_r10: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |=> open_q);

  p_pre_closes_r13: assert property (@(posedge clk) disable iff (!rst_n)
    do_pre |=> !open_q);

  p_overrun_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rules[RULE_TRAS_MAX] |=> !rules[RULE_TRAS_MAX]);

  p_col_after_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (do_act && TRCD_CYC > 1) |=> (!do_col || rules[RULE_TRCD]));

endmodule

// File: rtl/sdr_bus_track.sv
module sdr_bus_track
  import sdr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS),
  parameter int TRRD_CYC  = 2,
  parameter int TMRD_CYC  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  sdr_op_e         op,
  input  logic [BA_W-1:0] ba,
  output rule_vec_t       rules
);

  localparam int TOP_MAX = (TRRD_CYC > TMRD_CYC) ? TRRD_CYC : TMRD_CYC;
  localparam int CW      = $clog2(TOP_MAX + 1);

  logic [CW-1:0]   act_gap, mrs_gap;
  logic [BA_W-1:0] last_bank;

  logic any_act, any_mrs, any_cmd;
  assign any_act = (op == OP_ACT);
  assign any_mrs = (op == OP_MRS);
  assign any_cmd = (op != OP_NOP);

  always_comb begin
    rules             = '0;
    rules[RULE_TRRD]  = any_act && (ba != last_bank) && too_soon(32'(act_gap), TRRD_CYC);
    rules[RULE_TMRD]  = any_cmd && too_soon(32'(mrs_gap), TMRD_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_gap   <= CW'(TRRD_CYC);
      mrs_gap   <= CW'(TMRD_CYC);
      last_bank <= '0;
    end else begin
      act_gap <= any_act ? CW'(1) : CW'(sat_step(32'(act_gap), TRRD_CYC));
      mrs_gap <= any_mrs ? CW'(1) : CW'(sat_step(32'(mrs_gap), TMRD_CYC));
      if (any_act) last_bank <= ba;
    end
  end

  p_mode_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (any_mrs && TMRD_CYC > 1) |=> (!any_cmd || rules[RULE_TMRD]));

  p_cross_bank_act_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_act && TRRD_CYC > 1) |=> (!any_act || ba == $past(ba) || rules[RULE_TRRD]));

endmodule

// File: rtl/sdr_viol_arbiter.sv
module sdr_viol_arbiter
  import sdr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clear,
  input  logic [NUM_BANKS-1:0][RULE_N-1:0] bank_rules,
  input  rule_vec_t                        bus_rules,
  input  logic [BA_W-1:0]                  cmd_bank,
  output logic                             pulse,
  output logic                             flag,
  output logic [CODE_W-1:0]                code,
  output logic [BA_W-1:0]                  bank
);

  logic              any_hit;
  logic [CODE_W-1:0] pick_code;
  logic [BA_W-1:0]   pick_bank;

  // code-major, bank-minor priority scan
  always_comb begin
    any_hit   = 1'b0;
    pick_code = '0;
    pick_bank = '0;
    for (int c = 1; c < RULE_N; c++) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (!any_hit && (bank_rules[b][c] || (bus_rules[c] && cmd_bank == BA_W'(b)))) begin
          any_hit   = 1'b1;
          pick_code = CODE_W'(c);
          pick_bank = BA_W'(b);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      flag  <= 1'b0;
      code  <= '0;
      bank  <= '0;
    end else begin
      pulse <= any_hit;
      if (any_hit && (!flag || clear)) begin
        flag <= 1'b1;
        code <= pick_code;
        bank <= pick_bank;
      end else if (clear) begin
        flag <= 1'b0;
        code <= '0;
        bank <= '0;
      end
    end
  end

  p_pulse_sets_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> flag);

  p_first_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clear) |=> ($stable(code) && $stable(bank) && flag));

  p_code_nonzero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> (code != '0));

  p_clear_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !any_hit) |=> !flag);

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdr_mon_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int TRCD_CYC     = 2,
  parameter int TRP_CYC      = 2,
  parameter int TRAS_CYC     = 6,
  parameter int TRAS_MAX_CYC = 13334,
  parameter int TRC_CYC      = 8,
  parameter int TRRD_CYC     = 2,
  parameter int TWR_CYC      = 2,
  parameter int TMRD_CYC     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_cs_n,
  input  logic                         cmd_ras_n,
  input  logic                         cmd_cas_n,
  input  logic                         cmd_we_n,
  input  logic [$clog2(NUM_BANKS)-1:0] cmd_ba,
  input  logic                         cmd_a10,
  input  logic                         err_clear,
  output logic                         viol_pulse,
  output logic                         err_flag,
  output logic [3:0]                   err_code,
  output logic [$clog2(NUM_BANKS)-1:0] err_bank
);

  localparam int BA_W = $clog2(NUM_BANKS);

  sdr_op_e                          op;
  logic [NUM_BANKS-1:0]             bank_sel;
  logic                             pre_all;
  logic [NUM_BANKS-1:0][RULE_N-1:0] bank_rules;
  rule_vec_t                        bus_rules;

  sdr_cmd_decode #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_decode (
    .cs_n(cmd_cs_n), .ras_n(cmd_ras_n), .cas_n(cmd_cas_n), .we_n(cmd_we_n),
    .ba(cmd_ba), .a10(cmd_a10), .op(op), .bank_sel(bank_sel), .pre_all(pre_all)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdr_bank_track #(
      .TRCD_CYC(TRCD_CYC), .TRP_CYC(TRP_CYC), .TRAS_CYC(TRAS_CYC),
      .TRAS_MAX_CYC(TRAS_MAX_CYC), .TRC_CYC(TRC_CYC), .TWR_CYC(TWR_CYC)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .op(op), .sel(bank_sel[g]),
      .pre_all(pre_all), .rules(bank_rules[g])
    );
  end

  sdr_bus_track #(
    .NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .TRRD_CYC(TRRD_CYC), .TMRD_CYC(TMRD_CYC)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .op(op), .ba(cmd_ba), .rules(bus_rules)
  );

  sdr_viol_arbiter #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .clear(err_clear),
    .bank_rules(bank_rules), .bus_rules(bus_rules), .cmd_bank(cmd_ba),
    .pulse(viol_pulse), .flag(err_flag), .code(err_code), .bank(err_bank)
  );

endmodule

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;

  localparam int CLK_PERIOD  = 10;
  localparam int TRAS_MAX_TB = 40;

  localparam logic [2:0] T_NOP = 3'd0, T_ACT = 3'd1, T_RD = 3'd2, T_WR = 3'd3,
                         T_PRE = 3'd4, T_REF = 3'd5, T_MRS = 3'd6, T_DES = 3'd7;

  typedef struct packed {
    logic [2:0] op;
    logic [1:0] ba;
    logic       a10;
    logic       clr;
    logic       pulse;
    logic       flag;
    logic [3:0] code;
    logic [1:0] bank;
    logic [3:0] req;
  } vec_t;

  // one entry per clock: command, clear, then expected outputs one edge later
  localparam vec_t VECS [0:30] = '{
    '{T_MRS, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 4'd9 },  // R9 mode load
    '{T_NOP, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 4'd9 },  // R9 nop not checked
    '{T_ACT, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 4'd9 },  // R9 gap 2 ok
    '{T_RD,  2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1,  2'd0, 4'd2 },  // R2 read 1 after act
    '{T_RD,  2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  2'd0, 4'd11},  // R11 + clear
    '{T_WR,  2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 4'd11},  // R11
    '{T_RD,  2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 4'd11},  // R11
    '{T_PRE, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3,  2'd0, 4'd4 },  // R4 open only 5
    '{T_ACT, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd2,  2'd0, 4'd3 },  // R3 beats R6 code
    '{T_ACT, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd6,  2'd1, 4'd7 },  // R7 other bank gap 1
    '{T_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  2'd0, 4'd12},  // R12 clear
    '{T_ACT, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 4'd7 },  // R7 gap 2 ok
    '{T_ACT, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5,  2'd0, 4'd6 },  // R6 (also 6,10)
    '{T_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  2'd0, 4'd12},  // R12 clear
    '{T_RD,  2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 4'd9,  2'd3, 4'd10},  // R10 closed bank
    '{T_WR,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  2'd0, 4'd11},  // R11 write, clear
    '{T_PRE, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7,  2'd1, 4'd8 },  // R8 recovery 1
    '{T_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  2'd0, 4'd12},  // R12 clear
    '{T_PRE, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 4'd13},  // R13 all, legal
    '{T_RD,  2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 4'd9,  2'd2, 4'd13},  // R13 bank2 closed
    '{T_ACT, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  2'd0, 4'd3 },  // R3 gap 2 ok
    '{T_MRS, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 4'd9 },  // R9
    '{T_RD,  2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8,  2'd3, 4'd9 },  // R9 cmd 1 after load
    '{T_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  2'd0, 4'd12},  // R12 clear
    '{T_REF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 4'd9 },  // R9 gap 3 ok
    '{T_ACT, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 4'd3 },  // R3
    '{T_NOP, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 4'd1 },  // R1
    '{T_ACT, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 4'd7 },  // R7 gap 2 ok
    '{T_PRE, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd3,  2'd1, 4'd12},  // R12 lowest bank
    '{T_RD,  2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3,  2'd1, 4'd12},  // R12 first holds
    '{T_DES, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  2'd0, 4'd1 }   // R1 deselect
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10, err_clear;
  logic [1:0] cmd_ba;
  logic       viol_pulse, err_flag;
  logic [3:0] err_code;
  logic [1:0] err_bank;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_monitor #(.TRAS_MAX_CYC(TRAS_MAX_TB)) i_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
    .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba), .cmd_a10(cmd_a10),
    .err_clear(err_clear), .viol_pulse(viol_pulse), .err_flag(err_flag),
    .err_code(err_code), .err_bank(err_bank)
  );

  task automatic drive(input logic [2:0] op, input logic [1:0] ba,
                       input logic a10, input logic clr);
    cmd_cs_n  = 1'b0;
    cmd_ba    = ba;
    cmd_a10   = a10;
    err_clear = clr;
    case (op)
      T_ACT:   {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'b011;
      T_RD:    {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'b101;
      T_WR:    {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'b100;
      T_PRE:   {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'b010;
      T_REF:   {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'b001;
      T_MRS:   {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'b000;
      T_DES: begin
        cmd_cs_n = 1'b1;
        {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'b000;
      end
      default: {cmd_ras_n, cmd_cas_n, cmd_we_n} = 3'b111;
    endcase
  endtask

  task automatic check(input bit ok, input int req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int outs();
    return {viol_pulse, err_flag, err_code, err_bank};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog expired: actual 0 expected 1");
    finish_run();
  end

  initial begin
    int hits;
    int first_k;
    rst_n = 1'b0;
    drive(T_NOP, 2'd0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(outs() == 0, 1, "reset outputs", outs(), 0);

    for (int i = 0; i < 31; i++) begin
      drive(VECS[i].op, VECS[i].ba, VECS[i].a10, VECS[i].clr);
      @(negedge clk);
      check(outs() == int'({VECS[i].pulse, VECS[i].flag, VECS[i].code, VECS[i].bank}),
            int'(VECS[i].req), $sformatf("vector %0d {pulse,flag,code,bank}", i),
            outs(), int'({VECS[i].pulse, VECS[i].flag, VECS[i].code, VECS[i].bank}));
    end

    // R5 row-open overrun reported exactly once, at open time TRAS_MAX_TB+1
    drive(T_NOP, 2'd0, 1'b0, 1'b1);
    @(negedge clk);
    check(err_flag == 1'b0, 12, "clear before overrun", int'(err_flag), 0);
    drive(T_ACT, 2'd0, 1'b0, 1'b0);
    hits    = 0;
    first_k = -1;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (k == 0) drive(T_NOP, 2'd0, 1'b0, 1'b0);
      if (viol_pulse) begin
        hits++;
        if (first_k < 0) first_k = k;
      end
    end
    check(hits == 1, 5, "overrun pulse count", hits, 1);
    check(first_k == TRAS_MAX_TB + 1, 5, "overrun cycle", first_k, TRAS_MAX_TB + 1);
    check({err_flag, err_code, err_bank} == {1'b1, 4'd4, 2'd0}, 5, "overrun code",
          int'({err_flag, err_code, err_bank}), int'({1'b1, 4'd4, 2'd0}));
    drive(T_PRE, 2'd0, 1'b0, 1'b1);
    @(negedge clk);
    check({viol_pulse, err_flag} == 2'b00, 5, "late precharge after overrun",
          int'({viol_pulse, err_flag}), 0);
    drive(T_NOP, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    finish_run();
  end

endmodule